// File: doc/BRIEF.md
# Timer Clock Gate with Busy Handshake

This block selects and gates the clock that drives a timer's prescaler and counter. Software writes a two-bit clock register holding a source-select field and a clock-enable bit. Every accepted change first runs through a modelled synchronizer. A busy flag stays high while it does, and the new setting only reaches the prescaler when busy drops. Writes that break the handshake rules are dropped: a write that changes both fields at once, and any clock-register write made while busy is high.

A second register holds the counter-run bit. It can only be set while the gated clock is actually running. A debug halt input freezes the prescaler and counter unless both a global run-in-debug bit and the block's own debug-run bit are high. The two sources are modelled as enables in the controlling clock domain. The bus clock source gives a pulse every cycle. The generic clock source gives a pulse whenever `gen_tick` is high. The prescaler and counter are included so that the effect of the gate can be seen at the ports.

Top module: `tmr_clkgate`

## Requirements
- R1: After reset, src_sel, clk_en, busy, ctr_en, clk_run, presc_tick and count are all zero.
- R2: A write to address 0 (bit 0 = clock enable, bit 1 = source select) that changes exactly one of the two fields while busy is low is stored at once, and busy is high in the following cycle.
- R3: A write to address 0 that would change both the select field and the enable bit is refused: both keep their old values and busy stays low.
- R4: A write to address 0 made while busy is high is ignored.
- R5: After an accepted change, busy is high for exactly SYNC_STAGES+1 cycles (3 by default).
- R6: A new enable value reaches clk_run only in the cycle in which busy falls. presc_tick stays low while clk_run is low, and counting stops once a disable has been applied.
- R7: A write to address 0 that changes neither field does not raise busy.
- R8: Writing one to address 1 bit 0 (counter run) has no effect while clk_run is low. Writing zero always clears the bit.
- R9: With select 0 the prescaler advances every cycle; with select 1 it advances only on cycles where gen_tick is high. presc_tick pulses once every PRESC_DIV advances (4 by default), and count increments on each pulse while ctr_en is high.
- R10: While dbg_halt is high, the prescaler and count are frozen unless dbg_run_all and dbg_run_self are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controlling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = clock register, 1 = counter-run register |
| bus_wdata | input | 2 | Write data (bit 0 enable/run, bit 1 source select) |
| gen_tick | input | 1 | Generic clock pulse, as seen in the controlling domain |
| dbg_halt | input | 1 | Debug halt is active |
| dbg_run_all | input | 1 | Global run-in-debug bit |
| dbg_run_self | input | 1 | This block's own debug-run bit |
| src_sel | output | 1 | Stored source-select field |
| clk_en | output | 1 | Stored clock-enable bit |
| busy | output | 1 | A change is in flight through the synchronizer |
| ctr_en | output | 1 | Counter-run bit |
| clk_run | output | 1 | The gated clock is applied and running |
| presc_tick | output | 1 | One-cycle prescaler output pulse |
| count | output | 8 | Counter value |

## Verification
A wrong busy count shows at the ports on the first cycle it differs. Busy either drops early, so clk_run changes too soon, or lingers, so a legal write placed right after it is lost and the stored fields are wrong one cycle later. A broken write filter shows in the stored field values on the cycle after the offending write. Prescaler, source or freeze faults only show as a count that drifts, so count deltas are measured over windows of 20 to 40 cycles. Those windows are chosen so the expected number of ticks does not depend on the prescaler's phase.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    localparam int CFG_W   = 2;
    localparam int EN_BIT  = 0;
    localparam int SEL_BIT = 1;
    localparam int RUN_BIT = 0;

    localparam logic ADDR_CLK = 1'b0;
    localparam logic ADDR_CTL = 1'b1;

    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_GEN = 1'b1
    } src_e;

    typedef struct packed {
        src_e sel;
        logic en;
    } clk_cfg_t;

    function automatic clk_cfg_t decode_cfg(input logic [CFG_W-1:0] d);
        clk_cfg_t c;
        c.sel = src_e'(d[SEL_BIT]);
        c.en  = d[EN_BIT];
        return c;
    endfunction

    function automatic logic is_frozen(input logic halt, input logic run_all,
                                       input logic run_self);
        return halt && !(run_all && run_self);
    endfunction

endpackage

// File: rtl/tcg_regs.sv
module tcg_regs
    import tcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             busy,
    input  logic             clk_run,
    output clk_cfg_t         cfg_q,
    output logic             ctr_en_q,
    output logic             change
);

    clk_cfg_t new_cfg;
    logic     sel_diff;
    logic     en_diff;
    logic     clk_wr;
    logic     ctl_wr;

    always_comb begin
        new_cfg  = decode_cfg(wdata);
        sel_diff = (new_cfg.sel != cfg_q.sel);
        en_diff  = (new_cfg.en != cfg_q.en);
        clk_wr   = wr && (addr == ADDR_CLK) && !busy;
        ctl_wr   = wr && (addr == ADDR_CTL);
        // exactly one field may move per write
        change   = clk_wr && (sel_diff ^ en_diff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{sel: SRC_BUS, en: 1'b0};
        end else if (change) begin
            cfg_q <= new_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_en_q <= 1'b0;
        end else if (ctl_wr) begin
            if (!wdata[RUN_BIT]) begin
                ctr_en_q <= 1'b0;
            end else if (clk_run) begin
                ctr_en_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tcg_sync.sv
module tcg_sync
    import tcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  clk_cfg_t cfg_in,
    output logic     busy,
    output clk_cfg_t cfg_applied
);

    localparam int BUSY_CYCLES = SYNC_STAGES + 1;
    localparam int BW          = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] remain_q;

    assign busy = (remain_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= BW'(BUSY_CYCLES);
        end else if (busy) begin
            remain_q <= remain_q - BW'(1);
        end
    end

    // the setting lands on the edge where busy drops
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_applied <= '{sel: SRC_BUS, en: 1'b0};
        end else if (remain_q == BW'(1)) begin
            cfg_applied <= cfg_in;
        end
    end

endmodule

// File: rtl/tcg_presc.sv
module tcg_presc
    import tcg_pkg::*;
#(
    parameter int PRESC_DIV = 4,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  clk_cfg_t         cfg_applied,
    input  logic             gen_tick,
    input  logic             frozen,
    input  logic             ctr_en,
    output logic             tick,
    output logic [CNT_W-1:0] count
);

    localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;

    logic          src_pulse;
    logic          advance;
    logic [PW-1:0] pcnt_q;

    always_comb begin
        src_pulse = (cfg_applied.sel == SRC_BUS) ? 1'b1 : gen_tick;
        advance   = cfg_applied.en && !frozen && src_pulse;
        tick      = advance && (pcnt_q == PW'(PRESC_DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else if (advance) begin
            pcnt_q <= pcnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick && ctr_en) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_clkgate.sv
module tmr_clkgate
    import tcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRESC_DIV   = 4,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [CFG_W-1:0] bus_wdata,
    input  logic             gen_tick,
    input  logic             dbg_halt,
    input  logic             dbg_run_all,
    input  logic             dbg_run_self,
    output logic             src_sel,
    output logic             clk_en,
    output logic             busy,
    output logic             ctr_en,
    output logic             clk_run,
    output logic             presc_tick,
    output logic [CNT_W-1:0] count
);

    clk_cfg_t cfg_q;
    clk_cfg_t cfg_applied;
    logic     change;
    logic     frozen;

    assign frozen  = is_frozen(dbg_halt, dbg_run_all, dbg_run_self);
    assign src_sel = cfg_q.sel;
    assign clk_en  = cfg_q.en;
    assign clk_run = cfg_applied.en;

    tcg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .busy     (busy),
        .clk_run  (clk_run),
        .cfg_q    (cfg_q),
        .ctr_en_q (ctr_en),
        .change   (change)
    );

    tcg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .start       (change),
        .cfg_in      (cfg_q),
        .busy        (busy),
        .cfg_applied (cfg_applied)
    );

    tcg_presc #(.PRESC_DIV(PRESC_DIV), .CNT_W(CNT_W)) u_presc (
        .clk         (clk),
        .rst         (rst),
        .cfg_applied (cfg_applied),
        .gen_tick    (gen_tick),
        .frozen      (frozen),
        .ctr_en      (ctr_en),
        .tick        (presc_tick),
        .count       (count)
    );

endmodule

// File: rtl/tcg_chk.sv
module tcg_chk
    import tcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [CFG_W-1:0] bus_wdata,
    input logic             dbg_halt,
    input logic             dbg_run_all,
    input logic             dbg_run_self,
    input logic             src_sel,
    input logic             clk_en,
    input logic             busy,
    input logic             ctr_en,
    input logic             clk_run,
    input logic             presc_tick,
    input logic [CNT_W-1:0] count
);

    localparam int BUSY_CYCLES = SYNC_STAGES + 1;

    logic [7:0] blen_q;
    logic       clk_wr_free;
    logic       sel_mv;
    logic       en_mv;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            blen_q <= '0;
        end else if (blen_q != 8'hFF) begin
            blen_q <= blen_q + 8'd1;
        end
    end

    assign clk_wr_free = bus_wr && (bus_addr == ADDR_CLK) && !busy;
    assign sel_mv      = (bus_wdata[SEL_BIT] != src_sel);
    assign en_mv       = (bus_wdata[EN_BIT] != clk_en);

    // R2
    single_change_busy_chk: assert property (@(posedge clk) disable iff (rst)
        clk_wr_free && (sel_mv != en_mv) |=> busy);

    // R3
    dual_change_refused_chk: assert property (@(posedge clk) disable iff (rst)
        clk_wr_free && sel_mv && en_mv |=> $stable(src_sel) && $stable(clk_en) && !busy);

    // R4
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy && bus_wr && (bus_addr == ADDR_CLK) |=> $stable(src_sel) && $stable(clk_en));

    // R5
    busy_not_too_long_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (blen_q < 8'(BUSY_CYCLES)));

    // R5
    busy_full_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen_q == 8'(BUSY_CYCLES)));

    // R6
    run_moves_on_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_run) |-> $fell(busy));

    // R6
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        presc_tick |-> clk_run);

    // R8
    ctr_set_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctr_en) |-> $past(clk_run));

    // R10
    freeze_holds_count_chk: assert property (@(posedge clk) disable iff (rst)
        is_frozen(dbg_halt, dbg_run_all, dbg_run_self) |=> $stable(count));

endmodule

bind tmr_clkgate tcg_chk #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .dbg_halt     (dbg_halt),
    .dbg_run_all  (dbg_run_all),
    .dbg_run_self (dbg_run_self),
    .src_sel      (src_sel),
    .clk_en       (clk_en),
    .busy         (busy),
    .ctr_en       (ctr_en),
    .clk_run      (clk_run),
    .presc_tick   (presc_tick),
    .count        (count)
);

// File: tb/test_tmr_clkgate.sv
`timescale 1ns/1ps
module test_tmr_clkgate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [1:0] bus_wdata = 2'b00;
    logic       gen_tick = 1'b0;
    logic       gen_on = 1'b0;
    logic       dbg_halt = 1'b0;
    logic       dbg_run_all = 1'b0;
    logic       dbg_run_self = 1'b0;
    logic       src_sel, clk_en, busy, ctr_en, clk_run, presc_tick;
    logic [7:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int c0;

    // 5-bit vector: {wdata[1:0], expected src_sel, clk_en, busy}
    localparam logic [4:0] VEC [0:6] = '{
        5'b10_1_0_1,   // R2 select moves to generic
        5'b01_1_0_0,   // R3 both fields change, refused
        5'b11_1_1_1,   // R2 enable
        5'b11_1_1_0,   // R7 no change
        5'b00_1_1_0,   // R3 both fields change, refused
        5'b10_1_0_1,   // R2 disable
        5'b00_0_0_1    // R2 select back to bus
    };

    always #4 clk = ~clk;

    always @(negedge clk) gen_tick <= gen_on ? ~gen_tick : 1'b0;

    tmr_clkgate i_tmr_clkgate (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .gen_tick(gen_tick), .dbg_halt(dbg_halt),
        .dbg_run_all(dbg_run_all), .dbg_run_self(dbg_run_self),
        .src_sel(src_sel), .clk_en(clk_en), .busy(busy), .ctr_en(ctr_en),
        .clk_run(clk_run), .presc_tick(presc_tick), .count(count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset(input string req);
        check(req, "src_sel", src_sel, 0);
        check(req, "clk_en", clk_en, 0);
        check(req, "busy", busy, 0);
        check(req, "ctr_en", ctr_en, 0);
        check(req, "clk_run", clk_run, 0);
        check(req, "presc_tick", presc_tick, 0);
        check(req, "count", count, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check_reset("R1");

        // R8: run bit refused while the clock is off
        wr_reg(1'b1, 2'b01);
        check("R8", "ctr_en with clock off", ctr_en, 0);

        for (int i = 0; i < 7; i++) begin
            wr_reg(1'b0, VEC[i][4:3]);
            check("R2/R3/R7", "src_sel", src_sel, VEC[i][2]);
            check("R2/R3/R7", "clk_en", clk_en, VEC[i][1]);
            check("R2/R3/R7", "busy", busy, VEC[i][0]);
            idle(4);
        end

        // R5/R6: enable on bus clock, walk the busy window
        wr_reg(1'b0, 2'b01);
        check("R5", "busy k1", busy, 1);
        check("R6", "clk_run k1", clk_run, 0);
        check("R6", "tick k1", presc_tick, 0);
        // R4: select change while busy is dropped
        wr_reg(1'b0, 2'b11);
        check("R5", "busy k3", busy, 1);
        check("R4", "src_sel during busy", src_sel, 0);
        check("R6", "clk_run k3", clk_run, 0);
        idle(1);
        check("R5", "busy k4", busy, 0);
        check("R6", "clk_run k4", clk_run, 1);
        check("R4", "src_sel after busy", src_sel, 0);

        wr_reg(1'b1, 2'b01);
        check("R8", "ctr_en with clock on", ctr_en, 1);

        // R9: bus source, divide by 4
        c0 = count;
        idle(40);
        check("R9", "bus source delta", int'(count) - c0, 10);

        // R10: frozen unless both run bits set
        dbg_halt = 1'b1; dbg_run_all = 1'b0; dbg_run_self = 1'b1;
        c0 = count;
        idle(20);
        check("R10", "halt delta", int'(count) - c0, 0);
        check("R10", "halt tick", presc_tick, 0);
        dbg_run_all = 1'b1;
        c0 = count;
        idle(20);
        check("R10", "run-in-debug delta", int'(count) - c0, 5);
        dbg_halt = 1'b0; dbg_run_all = 1'b0; dbg_run_self = 1'b0;

        // R9: generic source, pulses every other cycle
        wr_reg(1'b0, 2'b11);
        check("R9", "src_sel generic", src_sel, 1);
        idle(3);
        gen_on = 1'b1;
        idle(2);
        c0 = count;
        idle(40);
        check("R9", "generic source delta", int'(count) - c0, 5);

        // R6: disable stops counting once applied
        wr_reg(1'b0, 2'b10);
        idle(3);
        check("R6", "clk_run after disable", clk_run, 0);
        c0 = count;
        idle(20);
        check("R6", "delta after disable", int'(count) - c0, 0);
        check("R6", "tick after disable", presc_tick, 0);
        gen_on = 1'b0;

        // R8: clear always works, set refused again
        wr_reg(1'b1, 2'b00);
        check("R8", "ctr_en cleared", ctr_en, 0);
        wr_reg(1'b1, 2'b01);
        check("R8", "ctr_en with clock off again", ctr_en, 0);

        // R1: reset mid-run
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check_reset("R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule